// File: doc/BRIEF.md
# Snooping MSI Coherence Controller

This block keeps one small direct-mapped private cache coherent with its peers on a shared snooping bus. Every line carries one of three states: Invalid (no usable data), Shared (a clean copy that peers may also hold) or Modified (the only valid copy, newer than memory). Two request streams reach the controller. The processor side issues reads and writes, which are checked against the stored tag. The bus side presents read-miss, write-miss and invalidate transactions that other caches have issued. The controller answers both. It requests the bus and issues its own miss or invalidate when it wins the grant. It writes dirty blocks back to memory through a request/acknowledge port, and it hands a dirty block to a peer that misses on it.

Each block holds `BLK_WORDS` words. A processor word address is split, from most to least significant bit, into tag, index and word offset. Bus, snoop and memory addresses are block addresses, which are the word address without its offset bits. The processor side can have one request outstanding. `cpu_busy` stays high from acceptance until the cycle after `cpu_done`. A snooped transaction is held by the bus until `snoop_ack`.

The controller sequencer has six states:
- `C_IDLE` accepts work.
- `C_VICTWB` writes back a dirty victim.
- `C_ARB` requests the bus and waits for the grant.
- `C_FILL` reads the block from memory.
- `C_SNPWB` supplies and writes back a dirty block for a snoop.
- `C_RESP` signals completion to the processor.

The transitions are:
- `C_IDLE→C_RESP`: a read hit, or a write hit on Modified.
- `C_IDLE→C_VICTWB`: a miss that replaces a Modified line.
- `C_IDLE→C_ARB`: a miss on a clean or invalid line, or a write hit on Shared.
- `C_VICTWB→C_ARB`: the victim write-back is acknowledged.
- `C_ARB→C_FILL`: a miss command is issued.
- `C_ARB→C_RESP`: an invalidate is issued.
- `C_FILL→C_RESP`: the memory read is acknowledged.
- `C_IDLE→C_SNPWB` and `C_ARB→C_SNPWB`: a snoop hits a Modified line.
- `C_SNPWB→(C_IDLE or C_ARB)`: the snoop write-back is acknowledged, and the sequencer returns to the state it left.
- `C_RESP→C_IDLE`: always.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_busy`, `bus_req`, `mem_req`, `cpu_done` and `snoop_ack` are low; the first access to any address is a miss. A word address is {tag, index, offset}.
- R2: A processor read that hits a Shared or Modified line returns the word in `cpu_rdata` with `cpu_done`, and issues no bus command.
- R3: A processor read that finds the line Invalid, or finds a clean line with a different tag, issues a read miss (`bus_cmd`=1) for the block, then reads the block from memory, returns the word and leaves the line Shared.
- R4: A processor read or write that misses on a Modified line first writes the old block back to memory at its own block address, and only then issues its own miss command.
- R5: A processor write that hits a Shared line issues an invalidate (`bus_cmd`=3), stores the word, and leaves the line Modified with no memory access.
- R6: A processor write miss issues a write miss (`bus_cmd`=2), fetches the block from memory, merges the word at its offset and leaves the line Modified.
- R7: A processor write that hits a Modified line updates the word with no bus command and no memory access.
- R8: A snooped read miss (`snoop_cmd`=1) to a Shared line, or any snoop whose block is not held, is acknowledged in the same cycle with no memory write and no change to the line.
- R9: A snooped read miss to a Modified line drives the whole block on `snoop_data` with `snoop_supply`, writes it back to memory, acknowledges, and leaves the line Shared.
- R10: A snooped write miss (`snoop_cmd`=2) or invalidate (`snoop_cmd`=3) to a held block makes the line Invalid; if the line was Modified, it is first supplied and written back.
- R11: When a snoop and a processor request arrive in the same cycle, the snoop is served first. No bus command is issued in a cycle in which `snoop_valid` is high.
- R12: If a snooped invalidate or write miss removes a Shared line while a write upgrade waits for the grant, the write is issued as a write miss instead of an invalidate, and it ends with correct merged data.
- R13: A bus command is issued only in a cycle with `bus_gnt` high. `cpu_done` lasts one cycle. Once raised, `mem_req` and `mem_baddr` are held until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | WORD_W | Write word |
| cpu_busy | output | 1 | Request in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | WORD_W | Read word, valid with `cpu_done` |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 2 | Issued command: 0 none, 1 read miss, 2 write miss, 3 invalidate |
| bus_baddr | output | ADDR_W-OFF_W | Block address of the issued command |
| snoop_valid | input | 1 | A peer transaction is presented, held until `snoop_ack` |
| snoop_cmd | input | 2 | 1 read miss, 2 write miss, 3 invalidate |
| snoop_baddr | input | ADDR_W-OFF_W | Block address of the peer transaction |
| snoop_ack | output | 1 | Snoop handled this cycle |
| snoop_supply | output | 1 | This cache drives the dirty block |
| snoop_data | output | BLK_W | Supplied block |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write-back, 0 = block read |
| mem_baddr | output | ADDR_W-OFF_W | Memory block address |
| mem_wdata | output | BLK_W | Write-back block |
| mem_rdata | input | BLK_W | Read block, valid with `mem_ack` |
| mem_ack | input | 1 | Memory access complete |

## Verification
Processor traffic is tried in four forms:
- Repeated reads of one block, which tell a hit from a miss by whether a bus command appears.
- Writes to Shared, Modified and absent lines, which are told apart by which of invalidate, write miss or no command is issued.
- Tag conflicts on a clean line and on a dirty line, which differ by whether a memory write comes before the miss.
- A snoop that races a pending upgrade.

Snoops of each command type are aimed at Shared, Modified and absent lines. The later processor reads then show whether the line was kept, downgraded or dropped. The contents of memory after each write-back show whether the supplied block carried the newest words.

// File: rtl/msi_pkg.sv
`timescale 1ns/1ps
package msi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_st_t;

    typedef enum logic [1:0] {
        BUS_NONE   = 2'd0,
        BUS_RDMISS = 2'd1,
        BUS_WRMISS = 2'd2,
        BUS_INVAL  = 2'd3
    } bus_cmd_t;

    typedef enum logic [2:0] {
        C_IDLE   = 3'd0,
        C_VICTWB = 3'd1,
        C_ARB    = 3'd2,
        C_FILL   = 3'd3,
        C_SNPWB  = 3'd4,
        C_RESP   = 3'd5
    } ctl_st_t;

endpackage

// File: rtl/msi_line_store.sv
`timescale 1ns/1ps
// Tag, state and data arrays with two read ports (processor side, snoop side)
// and one write port owned by the sequencer.
module msi_line_store
    import msi_pkg::*;
#(
    parameter int IDX_W = 2,
    parameter int TAG_W = 7,
    parameter int BLK_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] a_idx,
    output logic [TAG_W-1:0] a_tag,
    output line_st_t         a_st,
    output logic [BLK_W-1:0] a_data,
    input  logic [IDX_W-1:0] b_idx,
    output logic [TAG_W-1:0] b_tag,
    output line_st_t         b_st,
    output logic [BLK_W-1:0] b_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  line_st_t         wr_st,
    input  logic [BLK_W-1:0] wr_data
);
    localparam int LINES = 1 << IDX_W;

    line_st_t         st_q  [LINES];
    logic [TAG_W-1:0] tag_q [LINES];
    logic [BLK_W-1:0] dat_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i]  <= LN_INV;
                tag_q[i] <= '0;
                dat_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                st_q[i]  <= wr_st;
                tag_q[i] <= wr_tag;
                dat_q[i] <= wr_data;
            end
        end
    end

    assign a_tag  = tag_q[a_idx];
    assign a_st   = st_q[a_idx];
    assign a_data = dat_q[a_idx];
    assign b_tag  = tag_q[b_idx];
    assign b_st   = st_q[b_idx];
    assign b_data = dat_q[b_idx];

endmodule

// File: rtl/msi_cpu_eval.sv
`timescale 1ns/1ps
// Classifies a processor access against the indexed line.
module msi_cpu_eval
    import msi_pkg::*;
#(
    parameter int TAG_W = 7
) (
    input  logic             we,
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_t         line_st,
    output logic             hit,
    output logic             local_done,
    output logic             upgrade,
    output logic             victim_dirty
);
    always_comb begin
        hit          = (line_st != LN_INV) && (line_tag == req_tag);
        local_done   = hit && (!we || (line_st == LN_MOD));
        upgrade      = hit && we && (line_st == LN_SHR);
        victim_dirty = !hit && (line_st == LN_MOD);
    end
endmodule

// File: rtl/msi_snoop_eval.sv
`timescale 1ns/1ps
// Decides the reaction of one line to a peer bus transaction.
module msi_snoop_eval
    import msi_pkg::*;
#(
    parameter int TAG_W = 7
) (
    input  logic             valid,
    input  logic [1:0]       cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_t         line_st,
    output logic             need_wb,
    output logic             change,
    output line_st_t         next_st
);
    logic match;
    logic is_rd;
    logic is_kill;

    always_comb begin
        match   = valid && (line_st != LN_INV) && (line_tag == snp_tag);
        is_rd   = (cmd == 2'(BUS_RDMISS));
        is_kill = (cmd == 2'(BUS_WRMISS)) || (cmd == 2'(BUS_INVAL));
        need_wb = match && (is_rd || is_kill) && (line_st == LN_MOD);
        change  = match && (is_kill || (is_rd && line_st == LN_MOD));
        next_st = line_st;
        if (match && is_kill)
            next_st = LN_INV;
        else if (match && is_rd && line_st == LN_MOD)
            next_st = LN_SHR;
    end
endmodule

// File: rtl/msi_snoop_ctrl.sv
`timescale 1ns/1ps
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 16,
    parameter int OFF_W  = 1,
    parameter int IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_we,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [WORD_W-1:0]         cpu_wdata,
    output logic                      cpu_busy,
    output logic                      cpu_done,
    output logic [WORD_W-1:0]         cpu_rdata,
    output logic                      bus_req,
    input  logic                      bus_gnt,
    output logic [1:0]                bus_cmd,
    output logic [ADDR_W-OFF_W-1:0]   bus_baddr,
    input  logic                      snoop_valid,
    input  logic [1:0]                snoop_cmd,
    input  logic [ADDR_W-OFF_W-1:0]   snoop_baddr,
    output logic                      snoop_ack,
    output logic                      snoop_supply,
    output logic [(WORD_W<<OFF_W)-1:0] snoop_data,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-OFF_W-1:0]   mem_baddr,
    output logic [(WORD_W<<OFF_W)-1:0] mem_wdata,
    input  logic [(WORD_W<<OFF_W)-1:0] mem_rdata,
    input  logic                      mem_ack
);
    localparam int BADDR_W = ADDR_W - OFF_W;
    localparam int TAG_W   = BADDR_W - IDX_W;
    localparam int BLK_W   = WORD_W << OFF_W;

    // ---------------- sequencer registers ----------------
    ctl_st_t           state, nxt;
    ctl_st_t           ret_q, ret_n;
    logic              we_q, we_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [WORD_W-1:0] wdat_q, wdat_n;
    logic [WORD_W-1:0] rdat_q, rdat_n;

    // ---------------- line store ----------------
    logic [IDX_W-1:0]  a_idx, b_idx, wr_idx;
    logic [TAG_W-1:0]  a_tag, b_tag, wr_tag;
    line_st_t          a_st, b_st, wr_st;
    logic [BLK_W-1:0]  a_data, b_data, wr_data;
    logic              wr_en;

    logic [ADDR_W-1:0] look_addr;
    logic [TAG_W-1:0]  look_tag;
    logic [OFF_W-1:0]  look_off;
    logic [TAG_W-1:0]  snp_tag;

    assign look_addr = (state == C_IDLE) ? cpu_addr : addr_q;
    assign look_off  = look_addr[OFF_W-1:0];
    assign a_idx     = look_addr[OFF_W +: IDX_W];
    assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
    assign b_idx     = snoop_baddr[IDX_W-1:0];
    assign snp_tag   = snoop_baddr[BADDR_W-1 -: TAG_W];

    msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx(a_idx), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
        .b_idx(b_idx), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_st(wr_st), .wr_data(wr_data)
    );

    logic c_hit, c_local, c_upgrade, c_victim;
    logic cpu_we_eff;
    assign cpu_we_eff = (state == C_IDLE) ? cpu_we : we_q;

    msi_cpu_eval #(.TAG_W(TAG_W)) u_cpu_eval (
        .we(cpu_we_eff), .req_tag(look_tag), .line_tag(a_tag), .line_st(a_st),
        .hit(c_hit), .local_done(c_local), .upgrade(c_upgrade), .victim_dirty(c_victim)
    );

    logic     s_need_wb, s_change;
    line_st_t s_next;

    msi_snoop_eval #(.TAG_W(TAG_W)) u_snoop_eval (
        .valid(snoop_valid), .cmd(snoop_cmd), .snp_tag(snp_tag),
        .line_tag(b_tag), .line_st(b_st),
        .need_wb(s_need_wb), .change(s_change), .next_st(s_next)
    );

    function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] blk,
                                                    input logic [OFF_W-1:0] off);
        return blk[off*WORD_W +: WORD_W];
    endfunction

    function automatic logic [BLK_W-1:0] put_word(input logic [BLK_W-1:0] blk,
                                                  input logic [OFF_W-1:0] off,
                                                  input logic [WORD_W-1:0] w);
        logic [BLK_W-1:0] r;
        r = blk;
        r[off*WORD_W +: WORD_W] = w;
        return r;
    endfunction

    logic snp_take;
    assign snp_take = snoop_valid && ((state == C_IDLE) || (state == C_ARB));

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= C_IDLE;
            ret_q  <= C_IDLE;
            we_q   <= 1'b0;
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else begin
            state  <= nxt;
            ret_q  <= ret_n;
            we_q   <= we_n;
            addr_q <= addr_n;
            wdat_q <= wdat_n;
            rdat_q <= rdat_n;
        end
    end

    // ---------------- next state and outputs ----------------
    always_comb begin
        nxt          = state;
        ret_n        = ret_q;
        we_n         = we_q;
        addr_n       = addr_q;
        wdat_n       = wdat_q;
        rdat_n       = rdat_q;
        wr_en        = 1'b0;
        wr_idx       = a_idx;
        wr_tag       = a_tag;
        wr_st        = a_st;
        wr_data      = a_data;
        cpu_busy     = (state != C_IDLE);
        cpu_done     = (state == C_RESP);
        cpu_rdata    = rdat_q;
        bus_req      = (state == C_ARB);
        bus_cmd      = 2'(BUS_NONE);
        bus_baddr    = addr_q[ADDR_W-1:OFF_W];
        snoop_ack    = 1'b0;
        snoop_supply = 1'b0;
        snoop_data   = '0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        mem_baddr    = addr_q[ADDR_W-1:OFF_W];
        mem_wdata    = '0;

        if (snp_take) begin
            // peer transaction first: it already owns the bus order
            if (s_need_wb) begin
                ret_n = state;
                nxt   = C_SNPWB;
            end else begin
                snoop_ack = 1'b1;
                if (s_change) begin
                    wr_en   = 1'b1;
                    wr_idx  = b_idx;
                    wr_tag  = b_tag;
                    wr_st   = s_next;
                    wr_data = b_data;
                end
            end
        end else begin
            unique case (state)
                C_IDLE: begin
                    if (cpu_req) begin
                        we_n   = cpu_we;
                        addr_n = cpu_addr;
                        wdat_n = cpu_wdata;
                        if (c_local) begin
                            nxt = C_RESP;
                            if (cpu_we) begin
                                wr_en   = 1'b1;
                                wr_data = put_word(a_data, look_off, cpu_wdata);
                            end else begin
                                rdat_n = pick_word(a_data, look_off);
                            end
                        end else if (c_victim) begin
                            nxt = C_VICTWB;
                        end else begin
                            nxt = C_ARB;
                        end
                    end
                end
                C_VICTWB: begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_baddr = {a_tag, a_idx};
                    mem_wdata = a_data;
                    if (mem_ack) begin
                        wr_en = 1'b1;
                        wr_st = LN_INV;
                        nxt   = C_ARB;
                    end
                end
                C_ARB: begin
                    if (bus_gnt) begin
                        if (c_upgrade) begin
                            bus_cmd = 2'(BUS_INVAL);
                            wr_en   = 1'b1;
                            wr_st   = LN_MOD;
                            wr_data = put_word(a_data, look_off, wdat_q);
                            nxt     = C_RESP;
                        end else if (we_q) begin
                            bus_cmd = 2'(BUS_WRMISS);
                            nxt     = C_FILL;
                        end else begin
                            bus_cmd = 2'(BUS_RDMISS);
                            nxt     = C_FILL;
                        end
                    end
                end
                C_FILL: begin
                    mem_req = 1'b1;
                    if (mem_ack) begin
                        wr_en  = 1'b1;
                        wr_tag = look_tag;
                        if (we_q) begin
                            wr_st   = LN_MOD;
                            wr_data = put_word(mem_rdata, look_off, wdat_q);
                        end else begin
                            wr_st   = LN_SHR;
                            wr_data = mem_rdata;
                            rdat_n  = pick_word(mem_rdata, look_off);
                        end
                        nxt = C_RESP;
                    end
                end
                C_SNPWB: begin
                    snoop_supply = 1'b1;
                    snoop_data   = b_data;
                    mem_req      = 1'b1;
                    mem_we       = 1'b1;
                    mem_baddr    = snoop_baddr;
                    mem_wdata    = b_data;
                    if (mem_ack) begin
                        snoop_ack = 1'b1;
                        wr_en     = 1'b1;
                        wr_idx    = b_idx;
                        wr_tag    = b_tag;
                        wr_st     = s_next;
                        wr_data   = b_data;
                        nxt       = ret_q;
                    end
                end
                C_RESP: begin
                    nxt = C_IDLE;
                end
                default: begin
                    nxt = C_IDLE;
                end
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_cmd_with_grant_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'(BUS_NONE)) |-> (bus_gnt && bus_req));

    assert_snoop_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != 2'(BUS_NONE)) |-> !snoop_valid);

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_baddr)));

    assert_supply_writes_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snoop_supply |-> (mem_req && mem_we));

    assert_victim_before_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !snoop_supply) |-> (bus_cmd == 2'(BUS_NONE) && cpu_busy));

endmodule

// File: tb/msi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_test;
    localparam int ADDR_W = 10;
    localparam int WORD_W = 16;
    localparam int OFF_W  = 1;
    localparam int IDX_W  = 2;
    localparam int BADDR_W = ADDR_W - OFF_W;
    localparam int BLK_W   = WORD_W << OFF_W;
    localparam int NBLK    = 1 << BADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic                cpu_req = 0, cpu_we = 0;
    logic [ADDR_W-1:0]   cpu_addr = '0;
    logic [WORD_W-1:0]   cpu_wdata = '0;
    logic                cpu_busy, cpu_done;
    logic [WORD_W-1:0]   cpu_rdata;
    logic                bus_req, bus_gnt;
    logic [1:0]          bus_cmd;
    logic [BADDR_W-1:0]  bus_baddr;
    logic                snoop_valid = 0;
    logic [1:0]          snoop_cmd = 0;
    logic [BADDR_W-1:0]  snoop_baddr = '0;
    logic                snoop_ack, snoop_supply;
    logic [BLK_W-1:0]    snoop_data;
    logic                mem_req, mem_we, mem_ack;
    logic [BADDR_W-1:0]  mem_baddr;
    logic [BLK_W-1:0]    mem_wdata, mem_rdata;

    msi_snoop_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_baddr(bus_baddr),
        .snoop_valid(snoop_valid), .snoop_cmd(snoop_cmd), .snoop_baddr(snoop_baddr),
        .snoop_ack(snoop_ack), .snoop_supply(snoop_supply), .snoop_data(snoop_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_baddr(mem_baddr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // ---------------- memory model: word at address a starts as 16'h4000 + a ----------------
    logic [BLK_W-1:0] mem [NBLK];
    int mem_cnt;
    int wb_count;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++)
                mem[b] <= {16'(16'h4000 + b*2 + 1), 16'(16'h4000 + b*2)};
            mem_ack   <= 1'b0;
            mem_cnt   <= 0;
            wb_count  <= 0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            if (mem_cnt == 2) begin
                mem_ack <= 1'b1;
                mem_cnt <= 0;
                if (mem_we) begin
                    mem[mem_baddr] <= mem_wdata;
                    wb_count <= wb_count + 1;
                end else begin
                    mem_rdata <= mem[mem_baddr];
                end
            end else begin
                mem_cnt <= mem_cnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    // ---------------- bus grant model ----------------
    logic gnt_en = 1'b1;
    always @(posedge clk) begin
        if (!rst_n) bus_gnt <= 1'b0;
        else        bus_gnt <= bus_req && gnt_en && !bus_gnt;
    end

    // ---------------- monitor ----------------
    int cmd_cnt = 0, sup_cnt = 0;
    logic [1:0] last_cmd = 0;
    logic [BLK_W-1:0] sup_data = '0;
    always @(negedge clk) begin
        if (rst_n && bus_cmd != 2'd0) begin
            cmd_cnt  <= cmd_cnt + 1;
            last_cmd <= bus_cmd;
        end
        if (rst_n && snoop_supply) begin
            sup_cnt  <= sup_cnt + 1;
            sup_data <= snoop_data;
        end
    end

    int n_checks = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [ADDR_W-1:0] a,
                          input logic [WORD_W-1:0] wd, output logic [WORD_W-1:0] rd);
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_done);
        rd = cpu_rdata;
        cpu_req = 0;
    endtask

    task automatic snoop_op(input logic [1:0] c, input logic [BADDR_W-1:0] ba);
        @(negedge clk);
        snoop_valid = 1; snoop_cmd = c; snoop_baddr = ba;
        forever begin
            #2;
            if (snoop_ack) break;
            @(negedge clk);
        end
        @(negedge clk);
        snoop_valid = 0;
    endtask

    // vector: {req[3:0], kind[2:0], addr[9:0], wdata[15:0], exp[31:0], cmd[1:0], wb[1:0]}
    // kind 0 read, 1 write, 2 snoop read miss, 3 snoop write miss, 4 snoop invalidate
    localparam int NV = 26;
    localparam logic [68:0] VECS [NV] = '{
        {4'd3,  3'd0, 10'h000, 16'h0000, 32'h0000_4000, 2'd1, 2'd0},  // R3 cold miss
        {4'd2,  3'd0, 10'h001, 16'h0000, 32'h0000_4001, 2'd0, 2'd0},  // R2 hit S
        {4'd5,  3'd1, 10'h001, 16'hBEEF, 32'h0000_0000, 2'd3, 2'd0},  // R5 upgrade
        {4'd7,  3'd1, 10'h000, 16'h1111, 32'h0000_0000, 2'd0, 2'd0},  // R7 write hit M
        {4'd2,  3'd0, 10'h001, 16'h0000, 32'h0000_BEEF, 2'd0, 2'd0},  // R2 hit M
        {4'd2,  3'd0, 10'h000, 16'h0000, 32'h0000_1111, 2'd0, 2'd0},  // R2
        {4'd4,  3'd0, 10'h008, 16'h0000, 32'h0000_4008, 2'd1, 2'd1},  // R4 dirty victim
        {4'd3,  3'd0, 10'h000, 16'h0000, 32'h0000_1111, 2'd1, 2'd0},  // R3 clean conflict
        {4'd2,  3'd0, 10'h001, 16'h0000, 32'h0000_BEEF, 2'd0, 2'd0},  // R2
        {4'd6,  3'd1, 10'h012, 16'h1234, 32'h0000_0000, 2'd2, 2'd0},  // R6 write miss
        {4'd9,  3'd2, 10'h012, 16'h0000, 32'h4013_1234, 2'd0, 2'd1},  // R9 supply
        {4'd9,  3'd0, 10'h013, 16'h0000, 32'h0000_4013, 2'd0, 2'd0},  // R9 still held
        {4'd9,  3'd1, 10'h013, 16'h2222, 32'h0000_0000, 2'd3, 2'd0},  // R9 now Shared
        {4'd8,  3'd2, 10'h000, 16'h0000, 32'h0000_0000, 2'd0, 2'd0},  // R8 snoop rd on S
        {4'd8,  3'd0, 10'h000, 16'h0000, 32'h0000_1111, 2'd0, 2'd0},  // R8 unchanged
        {4'd10, 3'd4, 10'h000, 16'h0000, 32'h0000_0000, 2'd0, 2'd0},  // R10 invalidate
        {4'd10, 3'd0, 10'h001, 16'h0000, 32'h0000_BEEF, 2'd1, 2'd0},  // R10 now miss
        {4'd6,  3'd1, 10'h004, 16'h5555, 32'h0000_0000, 2'd2, 2'd0},  // R6
        {4'd10, 3'd3, 10'h004, 16'h0000, 32'h4005_5555, 2'd0, 2'd1},  // R10 wrmiss on M
        {4'd10, 3'd0, 10'h004, 16'h0000, 32'h0000_5555, 2'd1, 2'd0},  // R10 miss, mem fresh
        {4'd8,  3'd3, 10'h00C, 16'h0000, 32'h0000_0000, 2'd0, 2'd0},  // R8 tag differs
        {4'd8,  3'd0, 10'h005, 16'h0000, 32'h0000_4005, 2'd0, 2'd0},  // R8 line kept
        {4'd6,  3'd1, 10'h006, 16'h7777, 32'h0000_0000, 2'd2, 2'd0},  // R6
        {4'd4,  3'd1, 10'h00E, 16'h8888, 32'h0000_0000, 2'd2, 2'd1},  // R4 write over M
        {4'd4,  3'd0, 10'h006, 16'h0000, 32'h0000_7777, 2'd1, 2'd1},  // R4 read over M
        {4'd3,  3'd0, 10'h00E, 16'h0000, 32'h0000_8888, 2'd1, 2'd0}   // R3
    };

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [WORD_W-1:0] rd;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check(!cpu_busy && !bus_req && !mem_req && !cpu_done && !snoop_ack, "R1",
              {27'd0, cpu_busy, bus_req, mem_req, cpu_done, snoop_ack}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [68:0] v;
            logic [3:0] rq; logic [2:0] kind; logic [9:0] a;
            logic [15:0] wd; logic [31:0] ex; logic [1:0] ec, ew;
            int c0, w0, s0;
            logic [1:0] seen;
            string tag;
            v = VECS[i];
            {rq, kind, a, wd, ex, ec, ew} = v;
            tag = $sformatf("R%0d vec%0d", rq, i);
            c0 = cmd_cnt; w0 = wb_count; s0 = sup_cnt;
            rd = '0;
            if (kind < 3'd2) cpu_op(kind[0], a, wd, rd);
            else             snoop_op(2'(kind - 3'd1), a[ADDR_W-1:OFF_W]);
            @(negedge clk);
            seen = (cmd_cnt != c0) ? last_cmd : 2'd0;
            check(seen == ec, {tag, " bus command"}, 32'(seen), 32'(ec));
            check((wb_count - w0) == int'(ew), {tag, " write-backs"}, 32'(wb_count - w0), 32'(ew));
            if (kind == 3'd0)
                check(rd == ex[15:0], {tag, " read data"}, 32'(rd), ex);
            if (kind >= 3'd2)
                check((sup_cnt != s0) == (ew != 0), {tag, " supply"}, 32'(sup_cnt - s0), 32'(ew));
            if (kind >= 3'd2 && ew != 0)
                check(sup_data == ex, {tag, " supplied block"}, sup_data, ex);
        end

        // R12: upgrade loses its Shared copy while waiting for the grant
        begin
            int c0;
            gnt_en = 1'b0;
            c0 = cmd_cnt;
            @(negedge clk);
            cpu_req = 1; cpu_we = 1; cpu_addr = 10'h000; cpu_wdata = 16'hABCD;
            do @(negedge clk); while (!bus_req);
            check(cpu_busy, "R13 busy while waiting", 32'(cpu_busy), 32'd1);
            snoop_op(2'd3, 9'h000);
            gnt_en = 1'b1;
            do @(negedge clk); while (!cpu_done);
            cpu_req = 0;
            check(cmd_cnt == c0 + 1 && last_cmd == 2'd2, "R12 upgrade became write miss",
                  32'(last_cmd), 32'd2);
        end
        cpu_op(1'b0, 10'h001, 16'h0, rd);
        check(rd == 16'hBEEF, "R12 merged neighbour word", 32'(rd), 32'h0000BEEF);
        cpu_op(1'b0, 10'h000, 16'h0, rd);
        check(rd == 16'hABCD, "R12 written word", 32'(rd), 32'h0000ABCD);

        // R11: snoop and processor request in the same cycle
        @(negedge clk);
        cpu_req = 1; cpu_we = 0; cpu_addr = 10'h000;
        snoop_valid = 1; snoop_cmd = 2'd1; snoop_baddr = 9'h100;
        #2;
        check(snoop_ack && !cpu_busy, "R11 snoop served first",
              {30'd0, snoop_ack, cpu_busy}, 32'd2);
        @(negedge clk);
        snoop_valid = 0;
        do @(negedge clk); while (!cpu_done);
        rd = cpu_rdata;
        cpu_req = 0;
        check(rd == 16'hABCD, "R11 processor served after", 32'(rd), 32'h0000ABCD);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule